// File: doc/BRIEF.md
# Slow-Clock System Timer with Alarm

This peripheral keeps time from a slow reference clock of roughly 32 kHz and presents it on a simple register bus.

A prescaler divides slow-clock rising edges into increments of a free-running real-time counter that wraps to zero. By default the counter is 20 bits wide. An absolute alarm compares the counter on every increment. A periodic interval timer counts raw slow-clock edges and raises an event each time it reaches a programmed period. The events, together with an external watchdog-overflow pulse, collect in a sticky status register that clears when it is read. Set and clear strobes on two write-only words edit an interrupt mask, and one level interrupt output reports the masked status.

The slow clock is brought into the bus clock domain by a synchronizer. An edge-detect state machine with two states, `LVL_LOW` and `LVL_HIGH`, turns it into ticks:
- `LVL_LOW` to `LVL_HIGH` happens when the synchronized level goes high, and emits exactly one tick.
- `LVL_HIGH` to `LVL_LOW` happens when the level goes low, with no tick.
- Each state otherwise holds.

Every piece of state then lives in the bus domain. A counter read therefore always returns a value the counter held. The bus clock must run at more than twice the slow clock.

Bus word addresses (`bus_addr`):

| Address | Register | Access |
|---|---|---|
| 0 | counter | read |
| 1 | prescale | read and write |
| 2 | alarm | read and write |
| 3 | period | read and write |
| 4 | status | read, clears on read |
| 5 | mask set | write |
| 6 | mask clear | write |
| 7 | mask | read |

Status bits: bit 0 is period elapsed, bit 1 is watchdog overflow, bit 2 is counter increment, bit 3 is alarm.

Top module: `slow_sys_timer`

## Requirements
- R1: After reset the registers read as follows: counter (word 0) 0, prescale (word 1) 32768, alarm (word 2) 0, period (word 3) 0, status (word 4) 0, mask (word 7) 0, and `irq` is low.
- R2: The counter (word 0) advances by one on every Nth slow-clock rising edge, where N is the prescale value (a value of 0 acts as 1). It wraps from 2^CNT_W-1 to 0, and every read returns a value it held.
- R3: A write to prescale (word 1) restarts both the counter and the prescale phase at zero.
- R4: Status bit 2 sets on every counter increment.
- R5: Status bit 3 sets when the counter steps onto the alarm value (word 2). Writing the alarm with the counter's current value does not fire until the counter wraps and returns to it.
- R6: A write to the alarm register clears a pending status bit 3.
- R7: With period P nonzero (word 3), status bit 0 sets on every Pth slow-clock rising edge. A period write restarts the interval count, and a period of 0 stops it.
- R8: A one-cycle pulse on `wdt_evt` sets status bit 1.
- R9: A read of status (word 4) returns the pending bits and clears them all. A bit whose event occurs in that same cycle stays set.
- R10: Ones written to word 5 set mask bits and ones written to word 6 clear them. Zero bits leave the mask unchanged, and word 7 reads the mask.
- R11: `irq` is high exactly while some status bit and its mask bit are both set, and it stays high until those bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Slow reference clock, asynchronous to clk |
| wdt_evt | input | 1 | Watchdog overflow event pulse |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Level interrupt from masked status |

## Verification
The hardest situation to reach is an alarm written with the counter's own current value: it must stay silent for a whole wrap of the counter and then fire on the return. A 20-bit counter makes that wrap far too long to reach. The bench therefore builds the timer with an 8-bit counter and a prescale of 1, then drives 255 slow-clock edges and confirms that no alarm has fired. One more edge must then fire it. Prescale and period values are swept over small ranges, and status is read after every slow edge, so that each increment and interval event is predicted arithmetically. A watchdog pulse is placed in the same cycle as a status read to show that the event survives the clear.

// File: rtl/st_pkg.sv
package st_pkg;
    localparam int ADDR_W  = 4;
    localparam int NUM_EVT = 4;

    localparam int EV_PIT = 0;
    localparam int EV_WDT = 1;
    localparam int EV_INC = 2;
    localparam int EV_ALM = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_COUNT  = 4'd0,
        A_PRESC  = 4'd1,
        A_ALARM  = 4'd2,
        A_PERIOD = 4'd3,
        A_STATUS = 4'd4,
        A_MSET   = 4'd5,
        A_MCLR   = 4'd6,
        A_MASK   = 4'd7
    } reg_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;
endpackage

// File: rtl/st_slow_edge.sv
module st_slow_edge
    import st_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_clk,
    output logic tick
);
    logic [SYNC_STAGES-1:0] sync_q;
    lvl_e state_q, state_d;
    logic level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], slow_clk};
    end

    assign level = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        tick    = 1'b0;
        unique case (state_q)
            LVL_LOW: if (level) begin
                state_d = LVL_HIGH;
                tick    = 1'b1;
            end
            LVL_HIGH: if (!level) state_d = LVL_LOW;
        endcase
    end

    // R2: each rising slow edge yields a single tick
    a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/st_rtc.sv
module st_rtc #(
    parameter int CNT_W   = 20,
    parameter int PRE_W   = 16,
    parameter int PRE_RST = 32768
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             presc_wr,
    input  logic [PRE_W-1:0] presc_wdata,
    input  logic             alarm_wr,
    input  logic [CNT_W-1:0] alarm_wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [PRE_W-1:0] presc_q,
    output logic [CNT_W-1:0] alarm_q,
    output logic             inc_evt,
    output logic             alm_evt
);
    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] lim;
    logic [CNT_W-1:0] cnt_nxt;
    logic             step;

    always_comb begin
        lim     = (presc_q == '0) ? PRE_W'(1) : presc_q;
        step    = tick && (({1'b0, phase_q} + (PRE_W+1)'(1)) >= {1'b0, lim});
        cnt_nxt = cnt_q + CNT_W'(1);
        inc_evt = step && !presc_wr;
        alm_evt = inc_evt && (cnt_nxt == alarm_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            cnt_q   <= '0;
            presc_q <= PRE_W'(PRE_RST);
            alarm_q <= '0;
        end else begin
            if (presc_wr) begin
                presc_q <= presc_wdata;
                phase_q <= '0;
                cnt_q   <= '0;
            end else if (tick) begin
                if (step) begin
                    phase_q <= '0;
                    cnt_q   <= cnt_nxt;
                end else begin
                    phase_q <= phase_q + PRE_W'(1);
                end
            end
            if (alarm_wr) alarm_q <= alarm_wdata;
        end
    end

    // R2: counter holds between ticks
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !presc_wr) |=> $stable(cnt_q));
    // R3: prescale write restarts the count
    a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
        presc_wr |=> (cnt_q == '0));
    // R5: alarm event lands the counter on the alarm value
    a_r5_alarm_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_evt && !alarm_wr) |=> (cnt_q == alarm_q));
endmodule

// File: rtl/st_pit.sv
module st_pit #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             per_wr,
    input  logic [PER_W-1:0] per_wdata,
    output logic [PER_W-1:0] per_q,
    output logic             pit_evt
);
    logic [PER_W-1:0] pcnt_q;
    logic             reach;

    always_comb begin
        reach   = ({1'b0, pcnt_q} + (PER_W+1)'(1)) >= {1'b0, per_q};
        pit_evt = tick && (per_q != '0) && reach && !per_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q  <= '0;
            pcnt_q <= '0;
        end else if (per_wr) begin
            per_q  <= per_wdata;
            pcnt_q <= '0;
        end else if (tick && per_q != '0) begin
            pcnt_q <= reach ? '0 : pcnt_q + PER_W'(1);
        end
    end

    // R7: interval count stays below a nonzero period
    a_r7_below: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q != '0) |-> (pcnt_q < per_q));
    // R7: an interval event restarts the count
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        pit_evt |=> (pcnt_q == '0));
endmodule

// File: rtl/slow_sys_timer.sv
module slow_sys_timer
    import st_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int PRE_W       = 16,
    parameter int PRE_RST     = 32768,
    parameter int PER_W       = 16,
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk,
    input  logic              wdt_evt,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq
);
    reg_e               addr_e;
    logic               wr_en, rd_en;
    logic               wr_presc, wr_alarm, wr_period, wr_mset, wr_mclr, rd_status;
    logic               tick, inc_evt, alm_evt, pit_evt;
    logic [CNT_W-1:0]   cnt, alarm;
    logic [PRE_W-1:0]   presc;
    logic [PER_W-1:0]   period;
    logic [NUM_EVT-1:0] evt, clr, st_q, mask_q, set_bits, clr_bits;
    logic               wdata_unused;

    assign addr_e       = reg_e'(bus_addr);
    assign wr_en        = bus_sel && bus_wr;
    assign rd_en        = bus_sel && !bus_wr;
    assign wr_presc     = wr_en && (addr_e == A_PRESC);
    assign wr_alarm     = wr_en && (addr_e == A_ALARM);
    assign wr_period    = wr_en && (addr_e == A_PERIOD);
    assign wr_mset      = wr_en && (addr_e == A_MSET);
    assign wr_mclr      = wr_en && (addr_e == A_MCLR);
    assign rd_status    = rd_en && (addr_e == A_STATUS);
    assign wdata_unused = ^bus_wdata;

    st_slow_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .tick(tick));

    st_rtc #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_rtc (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .presc_wr(wr_presc), .presc_wdata(bus_wdata[PRE_W-1:0]),
        .alarm_wr(wr_alarm), .alarm_wdata(bus_wdata[CNT_W-1:0]),
        .cnt_q(cnt), .presc_q(presc), .alarm_q(alarm),
        .inc_evt(inc_evt), .alm_evt(alm_evt));

    st_pit #(.PER_W(PER_W)) u_pit (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .per_wr(wr_period), .per_wdata(bus_wdata[PER_W-1:0]),
        .per_q(period), .pit_evt(pit_evt));

    always_comb begin
        evt         = '0;
        evt[EV_PIT] = pit_evt;
        evt[EV_WDT] = wdt_evt;
        evt[EV_INC] = inc_evt;
        evt[EV_ALM] = alm_evt;
        clr         = rd_status ? '1 : '0;
        if (wr_alarm) clr[EV_ALM] = 1'b1;
        set_bits    = wr_mset ? bus_wdata[NUM_EVT-1:0] : '0;
        clr_bits    = wr_mclr ? bus_wdata[NUM_EVT-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            mask_q <= '0;
        end else begin
            st_q   <= (st_q & ~clr) | evt;
            mask_q <= (mask_q | set_bits) & ~clr_bits;
        end
    end

    assign irq = |(st_q & mask_q);

    always_comb begin
        case (addr_e)
            A_COUNT:  bus_rdata = DW'(cnt);
            A_PRESC:  bus_rdata = DW'(presc);
            A_ALARM:  bus_rdata = DW'(alarm);
            A_PERIOD: bus_rdata = DW'(period);
            A_STATUS: bus_rdata = DW'(st_q);
            A_MASK:   bus_rdata = DW'(mask_q);
            default:  bus_rdata = '0;
        endcase
    end

    // R9: pending bits survive until a clearing access
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_status && !wr_alarm) |=> ((st_q & $past(st_q)) == $past(st_q)));
    // R9: an event in a clearing cycle wins
    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((st_q & $past(evt)) == $past(evt)));
    // R6: alarm write drops a pending alarm bit
    a_r6_alarm_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_alarm && !alm_evt) |=> !st_q[EV_ALM]);
    // R11: interrupt falls after a status read with no new event
    a_r11_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && evt == '0) |=> !irq);
    // R10: set strobe raises the written mask bits
    a_r10_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mset |=> ((mask_q & $past(bus_wdata[NUM_EVT-1:0])) == $past(bus_wdata[NUM_EVT-1:0])));
    // R10: clear strobe drops the written mask bits
    a_r10_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> ((mask_q & $past(bus_wdata[NUM_EVT-1:0])) == '0));
endmodule

// File: tb/slow_sys_timer_tb.sv
module slow_sys_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_clk = 1'b0;
    logic        wdt_evt = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    slow_sys_timer #(.CNT_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .wdt_evt(wdt_evt),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic slow_pulse();
        @(negedge clk); slow_clk = 1'b1;
        repeat (4) @(negedge clk);
        slow_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got 0 expected 1");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(4'd0, rv); chk("R1 count", rv, 0);
        rd(4'd1, rv); chk("R1 prescale", rv, 32768);
        rd(4'd2, rv); chk("R1 alarm", rv, 0);
        rd(4'd3, rv); chk("R1 period", rv, 0);
        rd(4'd4, rv); chk("R1 status", rv, 0);
        rd(4'd7, rv); chk("R1 mask", rv, 0);
        chk("R1 irq", irq, 0);

        // R10 mask set/clear
        wr(4'd5, 32'h5); rd(4'd7, rv); chk("R10 set", rv, 5);
        wr(4'd5, 32'h2); rd(4'd7, rv); chk("R10 set keeps", rv, 7);
        wr(4'd6, 32'h4); rd(4'd7, rv); chk("R10 clear", rv, 3);
        wr(4'd6, 32'h0); rd(4'd7, rv); chk("R10 zero no effect", rv, 3);
        wr(4'd6, 32'hF); rd(4'd7, rv); chk("R10 clear all", rv, 0);

        // R2 R3 R4 prescale sweep
        for (int p = 0; p <= 4; p++) begin
            int eff;
            eff = (p == 0) ? 1 : p;
            wr(4'd1, p);
            rd(4'd0, rv); chk("R3 restart", rv, 0);
            rd(4'd4, rv);
            for (int k = 1; k <= 3 * eff + 1; k++) begin
                slow_pulse();
                rd(4'd0, rv); chk("R2 count", rv, k / eff);
                rd(4'd4, rv); chk("R4 inc status", rv, (k % eff == 0) ? 4 : 0);
            end
        end

        // R5 alarm and wrap
        wr(4'd1, 1);
        wr(4'd2, 5);
        repeat (4) slow_pulse();
        rd(4'd4, rv); chk("R5 early", rv, 4);
        slow_pulse();
        rd(4'd4, rv); chk("R5 hit", rv, 12);
        wr(4'd2, 5);
        repeat (255) slow_pulse();
        rd(4'd4, rv); chk("R5 equal no fire", rv, 4);
        rd(4'd0, rv); chk("R2 wrap", rv, 4);
        slow_pulse();
        rd(4'd4, rv); chk("R5 fire after wrap", rv, 12);

        // R6 alarm write clears pending alarm, R11 irq
        wr(4'd2, 6);
        slow_pulse();
        wr(4'd5, 32'h8);
        chk("R11 irq alarm", irq, 1);
        wr(4'd2, 100);
        chk("R6 irq dropped", irq, 0);
        rd(4'd4, rv); chk("R6 alarm cleared", rv, 4);
        wr(4'd6, 32'hF);

        // R7 interval timer sweep
        wr(4'd1, 1000);
        rd(4'd4, rv);
        for (int per = 1; per <= 5; per++) begin
            wr(4'd3, per);
            for (int k = 1; k <= 2 * per + 1; k++) begin
                slow_pulse();
                rd(4'd4, rv); chk("R7 period", rv, (k % per == 0) ? 1 : 0);
            end
        end
        wr(4'd3, 0);
        repeat (3) slow_pulse();
        rd(4'd4, rv); chk("R7 stopped", rv, 0);

        // R8 R9 watchdog bit and clear on read
        @(negedge clk); wdt_evt = 1'b1;
        @(negedge clk); wdt_evt = 1'b0;
        rd(4'd4, rv); chk("R8 wdt bit", rv, 2);
        rd(4'd4, rv); chk("R9 cleared", rv, 0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd4; wdt_evt = 1'b1;
        #1 rv = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; wdt_evt = 1'b0;
        chk("R9 read same cycle", rv, 0);
        rd(4'd4, rv); chk("R9 event wins", rv, 2);

        // R11 irq masking
        wr(4'd5, 32'h2);
        @(negedge clk); wdt_evt = 1'b1;
        @(negedge clk); wdt_evt = 1'b0;
        chk("R11 irq set", irq, 1);
        rd(4'd4, rv);
        chk("R11 irq cleared", irq, 0);
        wr(4'd6, 32'h2);
        @(negedge clk); wdt_evt = 1'b1;
        @(negedge clk); wdt_evt = 1'b0;
        chk("R11 masked", irq, 0);
        wr(4'd5, 32'h2);
        chk("R11 late enable", irq, 1);
        rd(4'd4, rv);
        chk("R11 final clear", irq, 0);

        summary();
        $finish;
    end
endmodule